// File: doc/BRIEF.md
# Endpoint Transfer Retry Controller

This block decides, for each bus transaction that fails, whether to try it again or to give up and report an error. Every endpoint in a small set has its own programmable 2-bit error budget. Software writes that budget when the endpoint is configured. Each new transfer copies the budget into a working counter for that endpoint. A failed attempt uses up one unit of the working counter. The transfer ends with an error only on the attempt that takes the counter from one to zero. A budget of zero removes the limit, so a failing transfer is attempted again and again until one attempt passes.

Transfers run one at a time. A start request names an endpoint. The controller then raises an attempt request toward a stub bus interface and waits for a pass or fail result. When the transfer ends, the controller emits a one-cycle status report. The report carries the endpoint index, a success or error code, and the number of attempts used. An endpoint configured as isochronous always gets a budget of one, which gives it a single attempt.

Top module: `ep_retry_engine`

## Requirements
- R1: After reset, attemptReq and doneValid are 0, and every endpoint's programmed error count is 3.
- R2: A configuration write (cfgValid) stores cfgCount as the programmed count of endpoint cfgEp. When cfgIso is 1, the stored value is 1 whatever cfgCount holds, so an isochronous endpoint gets a single attempt.
- R3: A start request (startValid) is accepted only when attemptReq is 0. From the next cycle, attemptReq is 1 and attemptEp equals startEp. The working count is loaded from the programmed value; if a configuration write to the same endpoint falls in the same cycle, the newly written value is used. A start request while attemptReq is 1 is ignored, and attemptEp does not change.
- R4: A passing result (resultValid=1, resultPass=1) ends the transfer. In the next cycle the report has doneCode=0 (success). A success does not alter the programmed count.
- R5: With a programmed count N of 2 or 3, each failing result below the limit decrements the working count and leaves attemptReq at 1. The Nth consecutive failure ends the transfer with doneCode=1 (error) and doneAttempts=N.
- R6: With a programmed count of 1, the first failing result ends the transfer with doneCode=1 and doneAttempts=1.
- R7: With a programmed count of 0, failing results never end the transfer. Only a passing result ends it, with doneCode=0.
- R8: doneAttempts counts every result of the transfer, including the last one, and saturates at 2^ATT_W-1 (255 by default).
- R9: A configuration write to the endpoint of a running transfer leaves that transfer's limit unchanged. The new value takes effect at the next start.
- R10: doneValid is a single-cycle pulse, asserted in the same cycle that attemptReq falls. In that cycle, doneEp equals the endpoint of the finished transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgValid | input | 1 | Configuration write strobe |
| cfgEp | input | EP_W | Endpoint being configured |
| cfgCount | input | CNT_W | Programmed error count (0 = unlimited) |
| cfgIso | input | 1 | Isochronous endpoint: store a count of 1 |
| startValid | input | 1 | Start a new transfer |
| startEp | input | EP_W | Endpoint of the new transfer |
| attemptReq | output | 1 | A transfer is running; an attempt result is awaited |
| attemptEp | output | EP_W | Endpoint of the running transfer |
| resultValid | input | 1 | Attempt result strobe from the bus stub |
| resultPass | input | 1 | 1 = attempt passed, 0 = attempt failed |
| doneValid | output | 1 | Report pulse |
| doneEp | output | EP_W | Endpoint of the finished transfer |
| doneCode | output | 1 | 0 = success, 1 = error |
| doneAttempts | output | ATT_W | Attempts used, saturating |

## Verification
A configuration write can land in the same cycle as the start of a transfer, or in the same cycle as a failing result of a running transfer. The bench provokes both on purpose. In the first case, a write and a start to the same endpoint share one clock cycle. The test passes only if the transfer obeys the newly written budget. In the second case, a budget of 1 is written in the cycle that the first failure of a 3-budget transfer arrives. That transfer must still take three attempts before its error. The next transfer on the endpoint must then end after one attempt.

// File: rtl/ep_retry_pkg.sv
package ep_retry_pkg;

  // Report codes carried on doneCode
  typedef enum logic {
    CODE_OK  = 1'b0,
    CODE_ERR = 1'b1
  } code_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic beginXfer;
    logic decCount;
    logic clearCount;
    logic bumpAttempt;
    logic reportOk;
    logic reportErr;
  } strobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic cntIsOne;
    logic cntIsZero;
  } flags_t;

endpackage

// File: rtl/ep_retry_ctrl.sv
module ep_retry_ctrl
  import ep_retry_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cfgValid,
  input  logic    startValid,
  input  logic    resultValid,
  input  logic    resultPass,
  input  flags_t  flags,
  output strobe_t strb,
  output logic    attemptReq
);

  typedef enum logic {S_IDLE, S_TRY} state_e;
  state_e state, stateNext;

  always_comb begin
    strb         = '0;
    stateNext    = state;
    strb.loadCfg = cfgValid;
    case (state)
      S_IDLE: begin
        if (startValid) begin
          strb.beginXfer = 1'b1;
          stateNext      = S_TRY;
        end
      end
      S_TRY: begin
        if (resultValid) begin
          strb.bumpAttempt = 1'b1;
          if (resultPass) begin
            strb.reportOk = 1'b1;
            stateNext     = S_IDLE;
          end else if (flags.cntIsOne) begin
            // the 1 -> 0 step is the only way to an error
            strb.reportErr  = 1'b1;
            strb.clearCount = 1'b1;
            stateNext       = S_IDLE;
          end else if (!flags.cntIsZero) begin
            strb.decCount = 1'b1;
          end
          // count of zero: no limit, attempt again unchanged
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= stateNext;
  end

  assign attemptReq = (state == S_TRY);

endmodule

// File: rtl/ep_retry_dp.sv
module ep_retry_dp
  import ep_retry_pkg::*;
#(
  parameter int NUM_EP      = 4,
  parameter int CNT_W       = 2,
  parameter int ATT_W       = 8,
  parameter int RESET_COUNT = 3,
  parameter int EP_W        = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          strb,
  input  logic [EP_W-1:0]  cfgEp,
  input  logic [CNT_W-1:0] cfgCount,
  input  logic             cfgIso,
  input  logic [EP_W-1:0]  startEp,
  output flags_t           flags,
  output logic [EP_W-1:0]  curEp,
  output logic             doneValid,
  output logic [EP_W-1:0]  doneEp,
  output logic             doneCode,
  output logic [ATT_W-1:0] doneAttempts
);

  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_RESET = CNT_W'(RESET_COUNT);
  localparam logic [ATT_W-1:0] ATT_MAX   = '1;

  logic [CNT_W-1:0] progCnt [NUM_EP];
  logic [CNT_W-1:0] workCnt [NUM_EP];
  logic [CNT_W-1:0] cfgVal, startVal, curCnt;
  logic [ATT_W-1:0] attempts, attemptsNext;

  // isochronous endpoints are forced to a single attempt
  assign cfgVal   = cfgIso ? CNT_ONE : cfgCount;
  // a write to the starting endpoint in the same cycle is forwarded
  assign startVal = (strb.loadCfg && cfgEp == startEp) ? cfgVal : progCnt[startEp];

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    always_ff @(posedge clk) begin
      if (!rst_n)
        progCnt[e] <= CNT_RESET;
      else if (strb.loadCfg && cfgEp == EP_W'(e))
        progCnt[e] <= cfgVal;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)
        workCnt[e] <= '0;
      else if (strb.beginXfer && startEp == EP_W'(e))
        workCnt[e] <= startVal;
      else if (curEp == EP_W'(e)) begin
        if (strb.decCount)        workCnt[e] <= workCnt[e] - CNT_ONE;
        else if (strb.clearCount) workCnt[e] <= '0;
      end
    end
  end

  assign curCnt          = workCnt[curEp];
  assign flags.cntIsOne  = (curCnt == CNT_ONE);
  assign flags.cntIsZero = (curCnt == '0);

  assign attemptsNext = (attempts == ATT_MAX) ? attempts : attempts + ATT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curEp    <= '0;
      attempts <= '0;
    end else if (strb.beginXfer) begin
      curEp    <= startEp;
      attempts <= '0;
    end else if (strb.bumpAttempt) begin
      attempts <= attemptsNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      doneValid    <= 1'b0;
      doneEp       <= '0;
      doneCode     <= CODE_OK;
      doneAttempts <= '0;
    end else begin
      doneValid <= strb.reportOk | strb.reportErr;
      if (strb.reportOk | strb.reportErr) begin
        doneEp       <= curEp;
        doneCode     <= strb.reportErr ? CODE_ERR : CODE_OK;
        doneAttempts <= attemptsNext;
      end
    end
  end

endmodule

// File: rtl/ep_retry_engine.sv
module ep_retry_engine
  import ep_retry_pkg::*;
#(
  parameter int NUM_EP      = 4,
  parameter int CNT_W       = 2,
  parameter int ATT_W       = 8,
  parameter int RESET_COUNT = 3,
  parameter int EP_W        = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgValid,
  input  logic [EP_W-1:0]  cfgEp,
  input  logic [CNT_W-1:0] cfgCount,
  input  logic             cfgIso,
  input  logic             startValid,
  input  logic [EP_W-1:0]  startEp,
  output logic             attemptReq,
  output logic [EP_W-1:0]  attemptEp,
  input  logic             resultValid,
  input  logic             resultPass,
  output logic             doneValid,
  output logic [EP_W-1:0]  doneEp,
  output logic             doneCode,
  output logic [ATT_W-1:0] doneAttempts
);

  strobe_t strb;
  flags_t  flags;

  ep_retry_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfgValid   (cfgValid),
    .startValid (startValid),
    .resultValid(resultValid),
    .resultPass (resultPass),
    .flags      (flags),
    .strb       (strb),
    .attemptReq (attemptReq)
  );

  ep_retry_dp #(
    .NUM_EP     (NUM_EP),
    .CNT_W      (CNT_W),
    .ATT_W      (ATT_W),
    .RESET_COUNT(RESET_COUNT),
    .EP_W       (EP_W)
  ) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .cfgEp       (cfgEp),
    .cfgCount    (cfgCount),
    .cfgIso      (cfgIso),
    .startEp     (startEp),
    .flags       (flags),
    .curEp       (attemptEp),
    .doneValid   (doneValid),
    .doneEp      (doneEp),
    .doneCode    (doneCode),
    .doneAttempts(doneAttempts)
  );

endmodule

// File: rtl/ep_retry_engine_chk.sv
module ep_retry_engine_chk #(
  parameter int EP_W  = 2,
  parameter int ATT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             attemptReq,
  input logic [EP_W-1:0]  attemptEp,
  input logic             resultValid,
  input logic             resultPass,
  input logic             doneValid,
  input logic [EP_W-1:0]  doneEp,
  input logic             doneCode,
  input logic [ATT_W-1:0] doneAttempts
);

  a_r4_pass_reports_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (attemptReq && resultValid && resultPass) |=> (doneValid && doneCode == 1'b0));

  a_r5_error_needs_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (doneValid && doneCode) |-> $past(attemptReq && resultValid && !resultPass));

  a_r3_ep_held: assert property (@(posedge clk) disable iff (!rst_n)
    (attemptReq && $past(attemptReq)) |-> $stable(attemptEp));

  a_r8_attempts_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |-> (doneAttempts != '0));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |=> !doneValid);

  a_r10_fall_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(attemptReq) |-> (doneValid && doneEp == $past(attemptEp)));

  a_r10_done_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |-> !attemptReq);

endmodule

bind ep_retry_engine ep_retry_engine_chk #(.EP_W(EP_W), .ATT_W(ATT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .attemptReq  (attemptReq),
  .attemptEp   (attemptEp),
  .resultValid (resultValid),
  .resultPass  (resultPass),
  .doneValid   (doneValid),
  .doneEp      (doneEp),
  .doneCode    (doneCode),
  .doneAttempts(doneAttempts)
);

// File: tb/ep_retry_engine_tb_top.sv
module ep_retry_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_EP = 4;
  localparam int CNT_W  = 2;
  localparam int ATT_W  = 8;
  localparam int EP_W   = 2;
  localparam int ATT_SAT = (1 << ATT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgValid = 1'b0;
  logic [EP_W-1:0] cfgEp = '0;
  logic [CNT_W-1:0] cfgCount = '0;
  logic cfgIso = 1'b0;
  logic startValid = 1'b0;
  logic [EP_W-1:0] startEp = '0;
  logic attemptReq;
  logic [EP_W-1:0] attemptEp;
  logic resultValid = 1'b0;
  logic resultPass = 1'b0;
  logic doneValid;
  logic [EP_W-1:0] doneEp;
  logic doneCode;
  logic [ATT_W-1:0] doneAttempts;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  int progModel [NUM_EP];

  ep_retry_engine #(.NUM_EP(NUM_EP), .CNT_W(CNT_W), .ATT_W(ATT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfgValid(cfgValid), .cfgEp(cfgEp),
    .cfgCount(cfgCount), .cfgIso(cfgIso), .startValid(startValid),
    .startEp(startEp), .attemptReq(attemptReq), .attemptEp(attemptEp),
    .resultValid(resultValid), .resultPass(resultPass), .doneValid(doneValid),
    .doneEp(doneEp), .doneCode(doneCode), .doneAttempts(doneAttempts)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // stored value a configuration write produces
  function automatic int storedCount(input int cnt, input bit iso);
    return iso ? 1 : cnt;
  endfunction

  task automatic doCfg(input int ep, input int cnt, input bit iso);
    @(negedge clk);
    cfgValid = 1'b1; cfgEp = EP_W'(ep); cfgCount = CNT_W'(cnt); cfgIso = iso;
    @(negedge clk);
    cfgValid = 1'b0; cfgIso = 1'b0;
    progModel[ep] = storedCount(cnt, iso);
  endtask

  // startCfg/midCfg: -1 = none, otherwise count written at start / first result
  task automatic runXfer(input string tag, input int ep, input int nFails,
                         input bit intrude, input int startCfg, input int midCfg);
    int c, expAtt, expCode, k;
    bit ended;
    @(negedge clk);
    if (startCfg >= 0) begin
      cfgValid = 1'b1; cfgEp = EP_W'(ep); cfgCount = CNT_W'(startCfg); cfgIso = 1'b0;
      progModel[ep] = startCfg;
    end
    c = progModel[ep];
    if (c == 0 || nFails < c) begin expAtt = nFails + 1; expCode = 0; end
    else begin expAtt = c; expCode = 1; end
    startValid = 1'b1; startEp = EP_W'(ep);
    @(negedge clk);
    startValid = 1'b0; cfgValid = 1'b0;
    chk({tag, " R3 attemptReq after start"}, int'(attemptReq), 1);
    chk({tag, " R3 attemptEp"}, int'(attemptEp), ep);
    if (intrude) begin
      startValid = 1'b1; startEp = EP_W'((ep + 1) % NUM_EP);
      @(negedge clk);
      startValid = 1'b0;
      chk({tag, " R3 start while busy ignored, ep kept"}, int'(attemptEp), ep);
    end
    k = 0; ended = 1'b0;
    while (!ended && k < 2000) begin
      repeat ($urandom_range(0, 1)) @(negedge clk);
      resultValid = 1'b1; resultPass = (k >= nFails);
      if (k == 0 && midCfg >= 0) begin
        cfgValid = 1'b1; cfgEp = EP_W'(ep); cfgCount = CNT_W'(midCfg); cfgIso = 1'b0;
        progModel[ep] = midCfg;
      end
      @(negedge clk);
      resultValid = 1'b0; cfgValid = 1'b0;
      k++;
      if (doneValid) ended = 1'b1;
    end
    chk({tag, " R5/R7 results consumed"}, k, expAtt);
    chk({tag, " R10 doneValid"}, int'(doneValid), 1);
    chk({tag, " R10 attemptReq low at done"}, int'(attemptReq), 0);
    chk({tag, " R10 doneEp"}, int'(doneEp), ep);
    chk({tag, " R4/R5 doneCode"}, int'(doneCode), expCode);
    chk({tag, " R8 doneAttempts"}, int'(doneAttempts), (expAtt > ATT_SAT) ? ATT_SAT : expAtt);
    @(negedge clk);
    chk({tag, " R10 pulse ends"}, int'(doneValid), 0);
    if (intrude) begin
      @(negedge clk);
      chk({tag, " R3 ignored start left no transfer"}, int'(attemptReq), 0);
    end
  endtask

  initial begin
    void'($urandom(32'h00c0ffee));
    for (int i = 0; i < NUM_EP; i++) progModel[i] = 3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 attemptReq after reset", int'(attemptReq), 0);
    chk("R1 doneValid after reset", int'(doneValid), 0);

    // R1: reset count 3 -> three failures give an error
    runXfer("R1 reset count", 3, 10, 1'b0, -1, -1);
    // R5: count 3, all fail; count 2, one fail then pass
    doCfg(0, 3, 1'b0);
    runXfer("R5 count3", 0, 10, 1'b0, -1, -1);
    doCfg(1, 2, 1'b0);
    runXfer("R5 count2 pass", 1, 1, 1'b0, -1, -1);
    // R4: success left programmed count 2 in place
    runXfer("R4 count kept", 1, 5, 1'b0, -1, -1);
    // R6: count 1
    doCfg(2, 1, 1'b0);
    runXfer("R6 count1", 2, 4, 1'b0, -1, -1);
    // R2: isochronous forces 1 despite count 3
    doCfg(0, 3, 1'b1);
    runXfer("R2 iso", 0, 4, 1'b0, -1, -1);
    // R7: unlimited, ends on pass
    doCfg(3, 0, 1'b0);
    runXfer("R7 unlimited", 3, 6, 1'b0, -1, -1);
    // R8: saturation of attempt count
    runXfer("R8 saturate", 3, 300, 1'b0, -1, -1);
    // R3: start while busy ignored
    doCfg(1, 3, 1'b0);
    runXfer("R3 intrude", 1, 1, 1'b1, -1, -1);
    // R3: configuration forwarded into same-cycle start
    runXfer("R3 forward", 2, 5, 1'b0, 2, -1);
    // R9: write during a running transfer applies to next one
    doCfg(0, 3, 1'b0);
    runXfer("R9 in flight", 0, 7, 1'b0, -1, 1);
    runXfer("R9 next start", 0, 7, 1'b0, -1, -1);

    for (int n = 0; n < 150; n++) begin
      if ($urandom_range(0, 9) < 3)
        doCfg($urandom_range(0, NUM_EP - 1), $urandom_range(0, 3), $urandom_range(0, 4) == 0);
      runXfer("rnd R5/R6/R7", $urandom_range(0, NUM_EP - 1), $urandom_range(0, 4),
              $urandom_range(0, 9) == 0, -1, -1);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule